// File: doc/BRIEF.md
# Looping Audio DMA Channel Counter

This block is the address and count engine for one audio DMA channel that cycles through a ring buffer in memory. It keeps three registers: a buffer base address, a frame register, and a sample register. The frame register holds the current longword position together with the ring size in longwords minus one. The sample register holds the remaining samples in the current period together with a reload value. A two-bit byte leftover, kept out of view, records a position that is not on a longword boundary.

When the audio side offers a number of bytes it can take or supply, the block works out how many bytes to move and where in memory to start. It holds that request until the data mover reports completion with the number of bytes actually moved. It then advances the ring position and the sample count. At the end of a sample period it raises a one-cycle event. The memory transfer itself and the sample conversion sit outside the block.

Top module: `ring_dma_counter`

## Requirements
- R1: After reset, `base_o`, `frame_o` and `scount_o` are zero, the hidden leftover is zero, and `xfer_valid_o`, `eoc_o` and `unsup_o` are low.
- R2: `base_we_i` loads `base_o`. `scount_we_i` loads all of `scount_o`. `frame_we_i` loads all of `frame_o` and clears the byte leftover to zero.
- R3: A request (`req_valid_i` with no transfer outstanding) is accepted only while `enable_i` is 1 and `pause_i` is 0. Otherwise it produces no transfer and leaves every counter unchanged.
- R4: The sample shift is `fmt_i[0]` (stereo) plus `fmt_i[1]` (16-bit). The offered count is rounded down to a multiple of 1<<shift. A request whose computed length is zero is ignored.
- R5: The cycle after an accepted request, `xfer_valid_o` rises with `xfer_addr_o` = base + position*4 + leftover. Address and length stay stable until `done_i` is seen.
- R6: `xfer_len_o` is the smallest of three values: the rounded offer; the bytes left in the ring, ((size - position + 1)*4 + leftover), taken as zero when position > size; and the period bytes, (current + 1) << shift.
- R7: When the moved count equals the period bytes, `eoc_o` pulses high for the one cycle after `done_i`, and the current field (bits 31:16 of `scount_o`) is reloaded from bits 15:0.
- R8: Otherwise the current field becomes (period bytes - moved - 1) >> shift, and `eoc_o` stays low.
- R9: With sum = moved + leftover, the position advances by sum >> 2 and the new leftover is sum & 3.
- R10: With `loop_sel_i` = 0 (loop mode), a new position larger than the size (bits 15:0 of `frame_o`) becomes 0.
- R11: With `loop_sel_i` = 1 at completion, `frame_o` is left unchanged and `unsup_o` is set. `unsup_o` then stays high until reset.
- R12: `done_i` with no transfer outstanding changes no counter and raises no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Channel enable |
| pause_i | input | 1 | Channel pause (tie low for a record channel) |
| loop_sel_i | input | 1 | 0 = ring loop mode, 1 = one-shot (unsupported) |
| fmt_i | input | 2 | Bit 0 stereo, bit 1 16-bit |
| base_we_i | input | 1 | Base address write strobe |
| base_wdata_i | input | ADDR_W | Base address write data |
| frame_we_i | input | 1 | Frame register write strobe |
| scount_we_i | input | 1 | Sample register write strobe |
| cnt_wdata_i | input | 2*IDX_W | Frame/sample write data |
| req_valid_i | input | 1 | Byte offer strobe |
| offer_i | input | OFFER_W | Bytes the audio side can take or supply |
| xfer_valid_o | output | 1 | Transfer outstanding |
| xfer_addr_o | output | ADDR_W | Start address of the transfer |
| xfer_len_o | output | IDX_W+3 | Bytes to move |
| done_i | input | 1 | Transfer completion strobe |
| moved_i | input | IDX_W+3 | Bytes actually moved |
| eoc_o | output | 1 | End-of-count event pulse |
| unsup_o | output | 1 | Sticky one-shot mode flag |
| base_o | output | ADDR_W | Base address register |
| frame_o | output | 2*IDX_W | {position, size-1} |
| scount_o | output | 2*IDX_W | {current-1, reload-1} |

## Verification
On every cycle, the assertions check these rules:
- a posted length is never zero;
- a posted request holds steady until completion;
- no request starts while the channel is gated;
- the end-of-count event follows a completion;
- the loop-mode position never ends up past the size;
- one-shot completions leave the frame register alone and set the sticky flag;
- a stray completion changes nothing.

Only the bench's scenarios can show the exact values:
- the address with a leftover in play;
- the three-way length minimum under each of its limits;
- the rounding to whole samples;
- the partial-period arithmetic;
- the wrap to zero;
- the reload of the current sample field.

// File: rtl/ring_dma_pkg.sv
package ring_dma_pkg;
  function automatic logic [1:0] fmt_shift(input logic [1:0] fmt);
    return {1'b0, fmt[0]} + {1'b0, fmt[1]};
  endfunction
endpackage

// File: rtl/ring_dma_len.sv
module ring_dma_len #(
  parameter int ADDR_W  = 32,
  parameter int IDX_W   = 16,
  parameter int OFFER_W = 16,
  localparam int LW = IDX_W + 3
) (
  input  logic [ADDR_W-1:0]  base_i,
  input  logic [2*IDX_W-1:0] frame_i,
  input  logic [IDX_W-1:0]   cur_i,
  input  logic [1:0]         lo_i,
  input  logic [1:0]         shift_i,
  input  logic [OFFER_W-1:0] offer_i,
  output logic [ADDR_W-1:0]  addr_o,
  output logic [LW-1:0]      len_o
);
  logic [IDX_W-1:0] idx, size;
  logic [LW-1:0] left_b, per_b, offer_r, m1;

  assign idx  = frame_i[2*IDX_W-1:IDX_W];
  assign size = frame_i[IDX_W-1:0];

  always_comb begin
    left_b  = (idx > size) ? '0
            : (((LW'(size) - LW'(idx) + LW'(1)) << 2) + LW'(lo_i));
    per_b   = (LW'(cur_i) + LW'(1)) << shift_i;
    offer_r = LW'(offer_i) & ~((LW'(1) << shift_i) - LW'(1));
    m1      = (offer_r < left_b) ? offer_r : left_b;
    len_o   = (m1 < per_b) ? m1 : per_b;
    addr_o  = base_i + ADDR_W'({idx, 2'b00}) + ADDR_W'(lo_i);
  end
endmodule

// File: rtl/ring_dma_upd.sv
module ring_dma_upd #(
  parameter int IDX_W = 16,
  localparam int LW = IDX_W + 3
) (
  input  logic [2*IDX_W-1:0] frame_i,
  input  logic [2*IDX_W-1:0] scount_i,
  input  logic [1:0]         lo_i,
  input  logic [1:0]         shift_i,
  input  logic [LW-1:0]      moved_i,
  input  logic               loop_sel_i,
  output logic [2*IDX_W-1:0] frame_o,
  output logic [2*IDX_W-1:0] scount_o,
  output logic [1:0]         lo_o,
  output logic               hit_o
);
  logic [IDX_W-1:0] idx, size, cur, rld, cur_nx, idx_nx;
  logic [LW-1:0] per_b;
  logic [LW:0]   sum, new_idx;

  assign idx  = frame_i[2*IDX_W-1:IDX_W];
  assign size = frame_i[IDX_W-1:0];
  assign cur  = scount_i[2*IDX_W-1:IDX_W];
  assign rld  = scount_i[IDX_W-1:0];

  always_comb begin
    per_b   = (LW'(cur) + LW'(1)) << shift_i;
    hit_o   = (moved_i == per_b);
    cur_nx  = hit_o ? rld : IDX_W'((per_b - moved_i - LW'(1)) >> shift_i);
    sum     = (LW+1)'(moved_i) + (LW+1)'(lo_i);
    new_idx = (LW+1)'(idx) + (sum >> 2);
    // wrap only in loop mode; one-shot keeps the register as is
    idx_nx  = (new_idx > (LW+1)'(size)) ? '0 : new_idx[IDX_W-1:0];
    frame_o  = loop_sel_i ? frame_i : {idx_nx, size};
    scount_o = {cur_nx, rld};
    lo_o     = sum[1:0];
  end
endmodule

// File: rtl/ring_dma_counter.sv
module ring_dma_counter #(
  parameter int ADDR_W  = 32,
  parameter int IDX_W   = 16,
  parameter int OFFER_W = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 enable_i,
  input  logic                 pause_i,
  input  logic                 loop_sel_i,
  input  logic [1:0]           fmt_i,
  input  logic                 base_we_i,
  input  logic [ADDR_W-1:0]    base_wdata_i,
  input  logic                 frame_we_i,
  input  logic                 scount_we_i,
  input  logic [2*IDX_W-1:0]   cnt_wdata_i,
  input  logic                 req_valid_i,
  input  logic [OFFER_W-1:0]   offer_i,
  output logic                 xfer_valid_o,
  output logic [ADDR_W-1:0]    xfer_addr_o,
  output logic [IDX_W+2:0]     xfer_len_o,
  input  logic                 done_i,
  input  logic [IDX_W+2:0]     moved_i,
  output logic                 eoc_o,
  output logic                 unsup_o,
  output logic [ADDR_W-1:0]    base_o,
  output logic [2*IDX_W-1:0]   frame_o,
  output logic [2*IDX_W-1:0]   scount_o
);
  import ring_dma_pkg::*;
  localparam int LW = IDX_W + 3;

  logic [ADDR_W-1:0]  base_q, addr_q, addr_c;
  logic [2*IDX_W-1:0] frame_q, scount_q, frame_nx, scount_nx;
  logic [LW-1:0]      len_q, len_c;
  logic [1:0]         lo_q, lo_nx, shift_c, shift_q;
  logic               busy_q, eoc_q, unsup_q, hit, active;

  assign shift_c = fmt_shift(fmt_i);
  assign active  = enable_i & ~pause_i;

  ring_dma_len #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFFER_W(OFFER_W)) u_len (
    .base_i (base_q), .frame_i(frame_q), .cur_i(scount_q[2*IDX_W-1:IDX_W]),
    .lo_i   (lo_q), .shift_i(shift_c), .offer_i(offer_i),
    .addr_o (addr_c), .len_o(len_c)
  );

  ring_dma_upd #(.IDX_W(IDX_W)) u_upd (
    .frame_i (frame_q), .scount_i(scount_q), .lo_i(lo_q), .shift_i(shift_q),
    .moved_i (moved_i), .loop_sel_i(loop_sel_i),
    .frame_o (frame_nx), .scount_o(scount_nx), .lo_o(lo_nx), .hit_o(hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q   <= '0;
      frame_q  <= '0;
      scount_q <= '0;
      lo_q     <= '0;
      busy_q   <= 1'b0;
      addr_q   <= '0;
      len_q    <= '0;
      shift_q  <= '0;
      eoc_q    <= 1'b0;
      unsup_q  <= 1'b0;
    end else begin
      eoc_q <= 1'b0;
      if (!busy_q) begin
        if (req_valid_i && active && len_c != '0) begin
          busy_q  <= 1'b1;
          addr_q  <= addr_c;
          len_q   <= len_c;
          shift_q <= shift_c;
        end
      end else if (done_i) begin
        busy_q   <= 1'b0;
        frame_q  <= frame_nx;
        scount_q <= scount_nx;
        lo_q     <= lo_nx;
        eoc_q    <= hit;
        if (loop_sel_i) unsup_q <= 1'b1;
      end
      // software writes win over a same-cycle completion
      if (base_we_i) base_q <= base_wdata_i;
      if (frame_we_i) begin
        frame_q <= cnt_wdata_i;
        lo_q    <= '0;
      end
      if (scount_we_i) scount_q <= cnt_wdata_i;
    end
  end

  assign xfer_valid_o = busy_q;
  assign xfer_addr_o  = addr_q;
  assign xfer_len_o   = len_q;
  assign eoc_o        = eoc_q;
  assign unsup_o      = unsup_q;
  assign base_o       = base_q;
  assign frame_o      = frame_q;
  assign scount_o     = scount_q;
endmodule

// File: rtl/ring_dma_counter_chk.sv
module ring_dma_counter_chk #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 16
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               enable_i,
  input logic               pause_i,
  input logic               loop_sel_i,
  input logic               frame_we_i,
  input logic               scount_we_i,
  input logic               done_i,
  input logic               xfer_valid_o,
  input logic [ADDR_W-1:0]  xfer_addr_o,
  input logic [IDX_W+2:0]   xfer_len_o,
  input logic               eoc_o,
  input logic               unsup_o,
  input logic [2*IDX_W-1:0] frame_o,
  input logic [2*IDX_W-1:0] scount_o
);
  p_len_nonzero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_valid_o |-> xfer_len_o != '0);

  p_gate_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!xfer_valid_o && (!enable_i || pause_i)) |=> !xfer_valid_o);

  p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_valid_o && !done_i) |=>
      (xfer_valid_o && $stable(xfer_addr_o) && $stable(xfer_len_o)));

  p_eoc_src_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoc_o |-> $past(xfer_valid_o && done_i));

  p_wrap_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_valid_o && done_i && !loop_sel_i && !frame_we_i) |=>
      (frame_o[2*IDX_W-1:IDX_W] <= frame_o[IDX_W-1:0]));

  p_oneshot_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_valid_o && done_i && loop_sel_i && !frame_we_i) |=>
      ($stable(frame_o) && unsup_o));

  p_sticky_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unsup_o |=> unsup_o);

  p_stray_done_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!xfer_valid_o && !frame_we_i && !scount_we_i) |=>
      ($stable(frame_o) && $stable(scount_o) && !eoc_o));
endmodule

bind ring_dma_counter ring_dma_counter_chk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/ring_dma_counter_bench.sv
`timescale 1ns/100ps
module ring_dma_counter_bench;
  typedef struct packed {
    logic [31:0] fmt, frame, sc, offer, e_addr, e_len, moved, e_frame, e_sc, e_eoc;
  } vec_t;

  localparam vec_t VEC [4] = '{
    '{32'd3, 32'h0002_0007, 32'h0003_0009, 32'd100, 32'h1008, 32'd16, 32'd16, 32'h0006_0007, 32'h0009_0009, 32'd1},
    '{32'd0, 32'h0000_0003, 32'h0063_0005, 32'd7,   32'h1000, 32'd7,  32'd7,  32'h0001_0003, 32'h005C_0005, 32'd0},
    '{32'd1, 32'h0005_0005, 32'h0001_0000, 32'd9,   32'h1014, 32'd4,  32'd4,  32'h0000_0005, 32'h0000_0000, 32'd1},
    '{32'd2, 32'h0001_0009, 32'h000A_0003, 32'd20,  32'h1004, 32'd20, 32'd10, 32'h0003_0009, 32'h0005_0003, 32'd0}
  };

  logic clk = 0, rst_n = 0;
  logic enable = 0, pause = 0, loop_sel = 0;
  logic [1:0] fmt = 0;
  logic base_we = 0, frame_we = 0, scount_we = 0, req_valid = 0, done = 0;
  logic [31:0] base_wdata = 0, cnt_wdata = 0;
  logic [15:0] offer = 0;
  logic [18:0] moved = 0;
  logic xfer_valid, eoc, unsup;
  logic [31:0] xfer_addr, base_q, frame_q, scount_q;
  logic [18:0] xfer_len;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  ring_dma_counter u_ring_dma_counter (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(enable), .pause_i(pause),
    .loop_sel_i(loop_sel), .fmt_i(fmt), .base_we_i(base_we), .base_wdata_i(base_wdata),
    .frame_we_i(frame_we), .scount_we_i(scount_we), .cnt_wdata_i(cnt_wdata),
    .req_valid_i(req_valid), .offer_i(offer), .xfer_valid_o(xfer_valid),
    .xfer_addr_o(xfer_addr), .xfer_len_o(xfer_len), .done_i(done), .moved_i(moved),
    .eoc_o(eoc), .unsup_o(unsup), .base_o(base_q), .frame_o(frame_q), .scount_o(scount_q)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int which, input logic [31:0] v);
    @(negedge clk);
    if (which == 0) begin base_we = 1; base_wdata = v; end
    else if (which == 1) begin frame_we = 1; cnt_wdata = v; end
    else begin scount_we = 1; cnt_wdata = v; end
    @(negedge clk);
    base_we = 0; frame_we = 0; scount_we = 0;
  endtask

  task automatic issue(input logic [15:0] o);
    @(negedge clk);
    req_valid = 1; offer = o;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic complete(input logic [18:0] m);
    done = 1; moved = m;
    @(negedge clk);
    done = 0;
  endtask

  initial begin
    #(5.0 * 100000);
    total++; bad++;
    $display("FAIL watchdog act=hung exp=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 frame", frame_q, 0);
    chk("R1 scount", scount_q, 0);
    chk("R1 base", base_q, 0);
    chk("R1 valid", {31'd0, xfer_valid}, 0);
    chk("R1 unsup", {31'd0, unsup}, 0);
    chk("R1 eoc", {31'd0, eoc}, 0);
    rst_n = 1;
    wr(0, 32'h1000);
    chk("R2 base", base_q, 32'h1000);
    enable = 1;

    // vector walk: R4 R5 R6 R7 R8 R9 R10, R2 leftover clear on frame write (vec 2)
    for (int i = 0; i < 4; i++) begin
      fmt = VEC[i].fmt[1:0];
      wr(1, VEC[i].frame);
      wr(2, VEC[i].sc);
      chk("R2 frame write", frame_q, VEC[i].frame);
      issue(VEC[i].offer[15:0]);
      chk("R5 valid", {31'd0, xfer_valid}, 1);
      chk("R5 addr", xfer_addr, VEC[i].e_addr);
      chk("R6 len", {13'd0, xfer_len}, VEC[i].e_len);
      complete(VEC[i].moved[18:0]);
      chk("R7 eoc", {31'd0, eoc}, VEC[i].e_eoc);
      chk("R9 R10 frame", frame_q, VEC[i].e_frame);
      chk("R7 R8 scount", scount_q, VEC[i].e_sc);
      chk("R5 valid drop", {31'd0, xfer_valid}, 0);
    end

    // R9 leftover carried into address: frame {3,9}, lo 2, sc {5,3}, fmt 2
    issue(16'd100);
    chk("R9 addr leftover", xfer_addr, 32'h100E);
    chk("R6 len period", {13'd0, xfer_len}, 12);
    complete(19'd12);
    chk("R7 eoc", {31'd0, eoc}, 1);
    chk("R9 frame", frame_q, 32'h0006_0009);
    chk("R7 reload", scount_q, 32'h0003_0003);
    @(negedge clk);
    chk("R7 pulse one cycle", {31'd0, eoc}, 0);

    // R3 gating
    pause = 1;
    issue(16'd100);
    chk("R3 paused", {31'd0, xfer_valid}, 0);
    chk("R3 frame kept", frame_q, 32'h0006_0009);
    pause = 0; enable = 0;
    issue(16'd100);
    chk("R3 disabled", {31'd0, xfer_valid}, 0);
    enable = 1;

    // R4 offer below one sample
    fmt = 2'd3;
    issue(16'd3);
    chk("R4 sub-sample", {31'd0, xfer_valid}, 0);

    // R6 position past size
    wr(1, 32'h0008_0005);
    issue(16'd100);
    chk("R6 past size", {31'd0, xfer_valid}, 0);

    // R12 stray done
    @(negedge clk);
    complete(19'd4);
    chk("R12 eoc", {31'd0, eoc}, 0);
    chk("R12 frame", frame_q, 32'h0008_0005);
    chk("R12 scount", scount_q, 32'h0003_0003);

    // R11 one-shot
    loop_sel = 1; fmt = 2'd0;
    wr(1, 32'h0001_0003);
    wr(2, 32'h0001_0001);
    issue(16'd2);
    chk("R11 addr", xfer_addr, 32'h1004);
    chk("R11 len", {13'd0, xfer_len}, 2);
    complete(19'd2);
    chk("R11 frame kept", frame_q, 32'h0001_0003);
    chk("R11 unsup", {31'd0, unsup}, 1);
    chk("R7 eoc oneshot", {31'd0, eoc}, 1);
    loop_sel = 0;

    // R2 frame write clears leftover, R8 partial
    wr(1, 32'h0000_0003);
    issue(16'd1);
    chk("R2 leftover cleared", xfer_addr, 32'h1000);
    chk("R6 len", {13'd0, xfer_len}, 1);
    complete(19'd1);
    chk("R8 scount", scount_q, 32'h0000_0001);
    chk("R8 eoc", {31'd0, eoc}, 0);
    chk("R9 frame", frame_q, 32'h0000_0003);
    issue(16'd8);
    chk("R9 addr lo1", xfer_addr, 32'h1001);
    chk("R11 sticky", {31'd0, unsup}, 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule